// File: doc/BRIEF.md
# Stack Bound Trap Monitor

This block watches every change made to a CPU stack pointer. Each time the pointer is updated, it compares the new value with two programmable limits. One limit sets the lowest address the stack may grow down to. The other sets the highest address it may shrink back up to.

When a downward move goes below the low limit, or an upward move goes above the high limit, the block does three things:
- it latches a sticky flag for that kind of crossing;
- it raises a one-cycle trap request;
- it selects the return address that the trap entry sequence should save.

Which return address is saved depends on what moved the pointer. An implicit push, pop, call, return or exception entry saves the address of the next instruction. An explicit arithmetic instruction on the pointer saves the address one instruction further on.

Software programs the two limits and clears flags through a small register write port. The stack push sequence, the vector fetch and any reset generation are handled elsewhere.

Top module: `stack_guard`

## Requirements
- R1: When a valid update moves the pointer upward (`spNew > spOld`) to a value strictly greater than the high limit, `trapFlags[1]` (underflow) is set and `trapReq` is asserted.
- R2: When a valid update moves the pointer downward (`spNew < spOld`) to a value strictly below the low limit, `trapFlags[0]` (overflow) is set and `trapReq` is asserted.
- R3: For a trap caused by an implicit update (cause code 2'b01: push, pop, call, return or entry), `trapRetAddr` becomes `pcNext`.
- R4: For a trap caused by an explicit arithmetic update (cause code 2'b10), `trapRetAddr` becomes `pcNext2`, the instruction after the next one.
- R5: In these cases no trap is raised and no flag is set, whatever the pointer values:
  - `spUpdate` is low;
  - the cause code is 2'b00 (no update);
  - the cause code is 2'b11 (reserved).
- R6: `trapReq` is registered and appears in the clock cycle after the offending update. It lasts one cycle per offending update. `trapRetAddr` holds its value until the next trap.
- R7: Flags are sticky and are changed only by writes to the flag register:
  - a written 0 in bit i clears flag i;
  - a written 1 has no effect;
  - a crossing in the same cycle as a clearing write leaves the flag set.
- R8: Reset values are:
  - low limit 0x0000 and high limit 0xFFFF, so no crossing can occur until the limits are programmed;
  - flags 0, `trapReq` 0 and `trapRetAddr` 0.
- R9: Register writes are selected by `regSel`:
  - 0 writes the low (overflow) limit;
  - 1 writes the high (underflow) limit;
  - 2 writes the flag register, where bit 0 is overflow and bit 1 is underflow.

  Limits written in a cycle apply to updates in later cycles.
- R10: The comparison is strict and depends on direction:
  - landing exactly on a limit raises nothing;
  - a downward move is never checked against the high limit;
  - an upward move is never checked against the low limit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spUpdate | input | 1 | Stack pointer update strobe |
| updCause | input | 2 | Update cause: 00 none, 01 implicit, 10 explicit arithmetic, 11 reserved |
| spOld | input | SP_W | Pointer value before the update |
| spNew | input | SP_W | Pointer value after the update |
| pcNext | input | ADDR_W | Address of the next instruction |
| pcNext2 | input | ADDR_W | Address of the instruction after the next one |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 low limit, 1 high limit, 2 flags |
| regWrData | input | SP_W | Register write data |
| trapReq | output | 1 | One-cycle trap request |
| trapFlags | output | 2 | Sticky flags: bit 0 overflow, bit 1 underflow |
| trapRetAddr | output | ADDR_W | Return address to be saved for the last trap |

## Verification
The bench aims at the following corner cases:
- **Pointer lands exactly on a limit.** A non-strict compare would trap there.
- **Moves in the wrong direction past the other limit.** A design that ignores direction would raise a false underflow on a downward move.
- **Reserved and idle cause codes.** A design that decodes only the strobe would trap on them.
- **Write of ones to the flags.** A toggle or write-through register would change the flags.
- **A clearing write in the same cycle as a crossing.** A design that lets the clear win would lose the trap flag.
- **The two cause codes, including back-to-back traps.** A swapped address selector would save the wrong return address.
- **The cycle after each trap.** A request held as a level instead of a pulse would show here.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_IMPLICIT = 2'b01,
    CAUSE_EXPLICIT = 2'b10,
    CAUSE_RSVD     = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    SEL_LOW_LIM  = 2'd0,
    SEL_HIGH_LIM = 2'd1,
    SEL_FLAGS    = 2'd2,
    SEL_SPARE    = 2'd3
  } reg_sel_e;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_UNF = 1;
  localparam int NUM_FLAGS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic setOvf;
    logic setUnf;
    logic capture;
    logic useSkip;
  } guard_strobe_t;

endpackage

// File: rtl/stack_guard_ctrl.sv
module stack_guard_ctrl
  import stack_guard_pkg::*;
#(
  parameter int SP_W = 16
) (
  input  logic            spUpdate,
  input  logic [1:0]      updCause,
  input  logic [SP_W-1:0] spOld,
  input  logic [SP_W-1:0] spNew,
  input  logic [SP_W-1:0] lowLimit,
  input  logic [SP_W-1:0] highLimit,
  output guard_strobe_t   strb
);

  cause_e cause;
  logic   validCause;
  logic   active;
  logic   goingUp;
  logic   goingDown;

  always_comb begin
    cause      = cause_e'(updCause);
    validCause = (cause == CAUSE_IMPLICIT) || (cause == CAUSE_EXPLICIT);
    active     = spUpdate && validCause;
    goingUp    = spNew > spOld;
    goingDown  = spNew < spOld;

    strb.setUnf  = active && goingUp && (spNew > highLimit);
    strb.setOvf  = active && goingDown && (spNew < lowLimit);
    strb.capture = strb.setUnf || strb.setOvf;
    strb.useSkip = (cause == CAUSE_EXPLICIT);
  end

endmodule

// File: rtl/stack_guard_dp.sv
module stack_guard_dp
  import stack_guard_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  guard_strobe_t        strb,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [SP_W-1:0]      regWrData,
  input  logic [ADDR_W-1:0]    pcNext,
  input  logic [ADDR_W-1:0]    pcNext2,
  output logic [SP_W-1:0]      lowLimit,
  output logic [SP_W-1:0]      highLimit,
  output logic [NUM_FLAGS-1:0] trapFlags,
  output logic                 trapReq,
  output logic [ADDR_W-1:0]    trapRetAddr
);

  localparam logic [SP_W-1:0] LOW_RST  = '0;
  localparam logic [SP_W-1:0] HIGH_RST = '1;

  logic                 wrLow;
  logic                 wrHigh;
  logic                 wrFlags;
  logic [NUM_FLAGS-1:0] setVec;

  always_comb begin
    wrLow   = regWrEn && (reg_sel_e'(regSel) == SEL_LOW_LIM);
    wrHigh  = regWrEn && (reg_sel_e'(regSel) == SEL_HIGH_LIM);
    wrFlags = regWrEn && (reg_sel_e'(regSel) == SEL_FLAGS);
    setVec  = '0;
    setVec[FLAG_OVF] = strb.setOvf;
    setVec[FLAG_UNF] = strb.setUnf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowLimit  <= LOW_RST;
      highLimit <= HIGH_RST;
    end else begin
      if (wrLow)  lowLimit  <= regWrData;
      if (wrHigh) highLimit <= regWrData;
    end
  end

  // one sticky bit per flag: set wins over a clearing write
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trapFlags[i] <= 1'b0;
      end else if (setVec[i]) begin
        trapFlags[i] <= 1'b1;
      end else if (wrFlags && !regWrData[i]) begin
        trapFlags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trapReq     <= 1'b0;
      trapRetAddr <= '0;
    end else begin
      trapReq <= strb.capture;
      if (strb.capture) begin
        trapRetAddr <= strb.useSkip ? pcNext2 : pcNext;
      end
    end
  end

endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stack_guard_pkg::*;
#(
  parameter int SP_W   = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spUpdate,
  input  logic [1:0]        updCause,
  input  logic [SP_W-1:0]   spOld,
  input  logic [SP_W-1:0]   spNew,
  input  logic [ADDR_W-1:0] pcNext,
  input  logic [ADDR_W-1:0] pcNext2,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [SP_W-1:0]   regWrData,
  output logic              trapReq,
  output logic [1:0]        trapFlags,
  output logic [ADDR_W-1:0] trapRetAddr
);

  guard_strobe_t   strb;
  logic [SP_W-1:0] lowLimit;
  logic [SP_W-1:0] highLimit;

  stack_guard_ctrl #(.SP_W(SP_W)) u_ctrl (
    .spUpdate (spUpdate),
    .updCause (updCause),
    .spOld    (spOld),
    .spNew    (spNew),
    .lowLimit (lowLimit),
    .highLimit(highLimit),
    .strb     (strb)
  );

  stack_guard_dp #(.SP_W(SP_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .pcNext     (pcNext),
    .pcNext2    (pcNext2),
    .lowLimit   (lowLimit),
    .highLimit  (highLimit),
    .trapFlags  (trapFlags),
    .trapReq    (trapReq),
    .trapRetAddr(trapRetAddr)
  );

  logic validUpd;
  assign validUpd = spUpdate && (updCause == 2'b01 || updCause == 2'b10);

  assert_unf_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (validUpd && spNew > spOld && spNew > highLimit) |=> (trapReq && trapFlags[1]));

  assert_ovf_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (validUpd && spNew < spOld && spNew < lowLimit) |=> (trapReq && trapFlags[0]));

  assert_ret_implicit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && $past(updCause) == 2'b01) |-> (trapRetAddr == $past(pcNext)));

  assert_ret_explicit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && $past(updCause) == 2'b10) |-> (trapRetAddr == $past(pcNext2)));

  assert_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !validUpd |=> !trapReq);

  assert_ret_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trapReq |-> $stable(trapRetAddr));

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trapFlags[0]) |-> $past(regWrEn && regSel == 2'd2 && !regWrData[0]));

  assert_unf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trapFlags[1]) |-> $past(regWrEn && regSel == 2'd2 && !regWrData[1]));

endmodule

// File: tb/stack_guard_tb.sv
module stack_guard_tb;

  localparam int SP_W   = 16;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              spUpdate = 1'b0;
  logic [1:0]        updCause = 2'b00;
  logic [SP_W-1:0]   spOld = '0;
  logic [SP_W-1:0]   spNew = '0;
  logic [ADDR_W-1:0] pcNext = '0;
  logic [ADDR_W-1:0] pcNext2 = '0;
  logic              regWrEn = 1'b0;
  logic [1:0]        regSel = 2'd0;
  logic [SP_W-1:0]   regWrData = '0;
  logic              trapReq;
  logic [1:0]        trapFlags;
  logic [ADDR_W-1:0] trapRetAddr;

  always #5 clk = ~clk;

  stack_guard #(.SP_W(SP_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .spUpdate(spUpdate), .updCause(updCause),
    .spOld(spOld), .spNew(spNew), .pcNext(pcNext), .pcNext2(pcNext2),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .trapReq(trapReq), .trapFlags(trapFlags), .trapRetAddr(trapRetAddr)
  );

  typedef struct {
    logic              trap;
    logic [1:0]        flags;
    logic [ADDR_W-1:0] ret;
    string             tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [SP_W-1:0]   mLow = '0;
  logic [SP_W-1:0]   mHigh = '1;
  logic [1:0]        mFlags = 2'b00;
  logic [ADDR_W-1:0] mRet = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic upd, input logic [1:0] cause,
                      input logic [SP_W-1:0] oldV, input logic [SP_W-1:0] newV,
                      input logic [ADDR_W-1:0] pn, input logic [ADDR_W-1:0] pn2,
                      input logic we, input logic [1:0] sel,
                      input logic [SP_W-1:0] wd, input string tag);
    exp_t e;
    logic valid, setO, setU;
    @(negedge clk);
    spUpdate = upd; updCause = cause; spOld = oldV; spNew = newV;
    pcNext = pn; pcNext2 = pn2; regWrEn = we; regSel = sel; regWrData = wd;
    valid = upd && (cause == 2'b01 || cause == 2'b10);
    setO = valid && (newV < oldV) && (newV < mLow);
    setU = valid && (newV > oldV) && (newV > mHigh);
    if (setO || setU) mRet = (cause == 2'b10) ? pn2 : pn;
    if (we && sel == 2'd2) mFlags = mFlags & wd[1:0];
    if (setO) mFlags[0] = 1'b1;
    if (setU) mFlags[1] = 1'b1;
    if (we && sel == 2'd0) mLow = wd;
    if (we && sel == 2'd1) mHigh = wd;
    e.trap = setO || setU;
    e.flags = mFlags;
    e.ret = mRet;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic upd(input logic [1:0] cause, input logic [SP_W-1:0] oldV,
                     input logic [SP_W-1:0] newV, input logic [ADDR_W-1:0] pn,
                     input logic [ADDR_W-1:0] pn2, input string tag);
    step(1'b1, cause, oldV, newV, pn, pn2, 1'b0, 2'd0, '0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [SP_W-1:0] wd, input string tag);
    step(1'b0, 2'b00, '0, '0, '0, '0, 1'b1, sel, wd, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'b00, '0, '0, '0, '0, 1'b0, 2'd0, '0, tag);
  endtask

  // monitor: pops one expected item per clock once the driver has queued it
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " trapReq"}, 64'(trapReq), 64'(e.trap));
        check({e.tag, " trapFlags"}, 64'(trapFlags), 64'(e.flags));
        check({e.tag, " trapRetAddr"}, 64'(trapRetAddr), 64'(e.ret));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset trapReq", 64'(trapReq), 64'd0);
    check("R8 reset trapFlags", 64'(trapFlags), 64'd0);
    check("R8 reset trapRetAddr", 64'(trapRetAddr), 64'd0);
    rst_n = 1'b1;

    // R8: extreme default limits never trip
    upd(2'b01, 16'hFFF0, 16'hFFFE, 24'h000100, 24'h000104, "R8 default high limit");
    upd(2'b01, 16'h0010, 16'h0000, 24'h000110, 24'h000114, "R8 default low limit");

    // R9: program limits
    wr(2'd0, 16'h1000, "R9 write low limit");
    wr(2'd1, 16'hF000, "R9 write high limit");

    // R2 + R3: implicit downward crossing
    upd(2'b01, 16'h1004, 16'h0FFE, 24'h000200, 24'h000204, "R2 R3 overflow implicit");
    idle("R6 pulse ends, ret held");

    // R7: writing ones has no effect
    wr(2'd2, 16'h0003, "R7 write ones");

    // R1 + R4: explicit upward crossing
    upd(2'b10, 16'hEFFE, 16'hF002, 24'h000300, 24'h000308, "R1 R4 underflow explicit");
    idle("R6 idle after underflow");

    // R10: exact limit values and wrong-direction moves
    upd(2'b01, 16'hEFF0, 16'hF000, 24'h000400, 24'h000404, "R10 equal high limit");
    upd(2'b10, 16'h1010, 16'h1000, 24'h000410, 24'h000414, "R10 equal low limit");
    upd(2'b01, 16'hF100, 16'hF0F0, 24'h000420, 24'h000424, "R10 down above high");
    upd(2'b10, 16'h0100, 16'h0200, 24'h000430, 24'h000434, "R10 up below low");

    // R5: idle, reserved cause and strobe low
    upd(2'b00, 16'h1004, 16'h0004, 24'h000500, 24'h000504, "R5 cause none");
    upd(2'b11, 16'h1004, 16'h0004, 24'h000510, 24'h000514, "R5 cause reserved");
    step(1'b0, 2'b01, 16'hEFFE, 16'hFFFE, 24'h520, 24'h524, 1'b0, 2'd0, '0, "R5 strobe low");

    // R7: clear overflow only
    wr(2'd2, 16'h0002, "R7 clear bit0");

    // R7: clear-all write in the same cycle as a crossing; set wins
    step(1'b1, 2'b01, 16'h0800, 16'h07FE, 24'h000600, 24'h000604, 1'b1, 2'd2, 16'h0000,
         "R7 set beats clear");

    // R6 + R3/R4: back-to-back traps with different causes
    upd(2'b10, 16'h0700, 16'h06F0, 24'h000700, 24'h000708, "R6 R4 back to back 1");
    upd(2'b01, 16'hF000, 16'hF010, 24'h000710, 24'h000718, "R6 R3 back to back 2");
    idle("R6 idle after pair");

    wr(2'd2, 16'h0000, "R7 clear all");

    // R9: new limits apply afterward
    wr(2'd0, 16'h0000, "R9 low limit to zero");
    upd(2'b01, 16'h0004, 16'h0000, 24'h000800, 24'h000804, "R9 lowered limit no trap");
    idle("final idle");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule